// File: doc/BRIEF.md
# Flash Write Buffer Program Sequencer

This block takes bus write cycles from a host and runs the buffered-program handshake of a flash device. A setup command opens the sequence. An extended status bit tells the host whether the write buffer could be claimed. A count write follows, then a series of address-plus-data writes that fill a small buffer RAM, and finally a confirm command. Once the confirm is taken, the buffered items go one at a time to a program engine. The engine is modelled as a fixed number of clock cycles per item, and it shows each committed item on a one-cycle strobe.

Any malformed sequence aborts the operation and raises two error bits in the main status byte. These are an oversized count, a count written to a different block, a data address outside the declared window, or a wrong command where the confirm belongs. The error bits stay set until the next accepted setup. The ready bit of the status byte is low while the engine is committing items.

Top module: `wbuf_program_seq`

## Requirements
- R1: After reset, `status_o` reads 8'h80, `xstat_o` reads 8'h80 and `prog_we` is low.
- R2: A write of data 8'h5A while the engine is idle and no sequence is open sets `xstat_o[7]` to 1, clears status bits 5 and 4, and makes the next write the count. If the engine is busy, the same write sets `xstat_o[7]` to 0 and changes nothing else, so the host retries. `xstat_o` changes only on such a setup write.
- R3: The count write's data C (0 to 31) declares C+1 items. The write is rejected as in R5 if C exceeds 31 or if its address bits [23:16] differ from those of the setup write.
- R4: The first data write after the count sets the start address S, which need not be aligned. Exactly C+1 data writes are taken. A data write at address A is stored at buffer offset A-S, and a later write to the same offset replaces the earlier one.
- R5: A data write with A-S (unsigned) greater than C aborts the sequence. The abort sets status bits 5 and 4, so the status reads 8'hB0 while the engine is idle, and nothing is programmed.
- R6: The write after the last data item must carry 8'hC3 to start programming. Any other value aborts as in R5.
- R7: Programming presents offsets 0 to C in ascending order on `prog_addr` = S+offset and `prog_data`. The data is the last value loaded at that offset, or 8'hFF for an offset never loaded.
- R8: With D = PROG_DELAY and the confirm taken at clock edge E, item k is presented with `prog_we` high for exactly the one cycle that follows edge E+k*D+D-1.
- R9: `status_o[7]` is 0 from edge E up to edge E+(C+1)*D, and is 1 after that edge.
- R10: While no sequence is open, writes other than 8'h5A have no effect. This includes 8'hC3, and it includes any write made while the engine is programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | DATA_W | Command code, count or data item |
| status_o | output | 8 | Bit 7 ready, bit 5 sequence error, bit 4 program error |
| xstat_o | output | 8 | Bit 7 buffer available from the last setup |
| prog_we | output | 1 | One-cycle strobe per committed item |
| prog_addr | output | ADDR_W | Array address of the committed item |
| prog_data | output | DATA_W | Data of the committed item |

## Verification
Every write is captured at one rising edge, and status, extended status and error bits are valid one cycle later. The bench therefore reads them at the falling edge right after each write. The program strobes are logged at falling edges together with a free-running edge count. Each logged entry is compared with the confirm edge plus k*D+D-1, and the ready bit is read at the edge before E+(C+1)*D and at that edge itself, which pins the exact cycle it returns to 1. Abort and ignore cases are checked both through the status byte and by confirming that no strobe was logged.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    localparam logic [7:0] CMD_SETUP   = 8'h5A;
    localparam logic [7:0] CMD_CONFIRM = 8'hC3;

    localparam int ST_READY_BIT = 7;
    localparam int ST_SEQ_BIT   = 5;
    localparam int ST_PGM_BIT   = 4;
    localparam int XS_AVAIL_BIT = 7;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_COUNT,
        SQ_LOAD,
        SQ_CONFIRM
    } seq_state_e;

    typedef struct packed {
        logic ready;
        logic seq_err;
        logic pgm_err;
    } stat_flags_t;

    function automatic logic [7:0] pack_status(input stat_flags_t f);
        logic [7:0] s;
        s = '0;
        s[ST_READY_BIT] = f.ready;
        s[ST_SEQ_BIT]   = f.seq_err;
        s[ST_PGM_BIT]   = f.pgm_err;
        return s;
    endfunction

    function automatic logic [7:0] pack_xstat(input logic avail);
        logic [7:0] s;
        s = '0;
        s[XS_AVAIL_BIT] = avail;
        return s;
    endfunction

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cell_vec [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [DATA_W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cell_q <= '1;
            end else if (we && (widx == IDX_W'(i))) begin
                cell_q <= wdata;
            end
        end
        assign cell_vec[i] = cell_q;
    end

    assign rdata = cell_vec[ridx];

endmodule

// File: rtl/wbuf_cmd_fsm.sv
module wbuf_cmd_fsm
    import wbuf_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 32,
    parameter int BLK_LSB = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int BLK_W  = ADDR_W - BLK_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              eng_busy,
    output logic              buf_clr,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              launch,
    output logic [ADDR_W-1:0] launch_start,
    output logic [IDX_W-1:0]  launch_last,
    output logic              avail,
    output logic              seq_err,
    output logic              pgm_err
);

    seq_state_e        state_q;
    logic [BLK_W-1:0]  block_q;
    logic [ADDR_W-1:0] start_q;
    logic [IDX_W-1:0]  last_q;
    logic [IDX_W-1:0]  loaded_q;
    logic              first_item;
    logic [7:0]        cmd;
    logic [ADDR_W-1:0] offset;
    logic              in_window;
    logic              count_ok;
    logic              setup_hit;

    assign cmd        = bus_wdata[7:0];
    assign first_item = (loaded_q == '0) && (state_q == SQ_LOAD);
    assign offset     = bus_addr - start_q;
    assign in_window  = offset <= ADDR_W'(last_q);
    assign count_ok   = (bus_wdata <= DATA_W'(DEPTH - 1)) &&
                        (bus_addr[ADDR_W-1:BLK_LSB] == block_q);
    assign setup_hit  = bus_we && (state_q == SQ_IDLE) && (cmd == CMD_SETUP);

    assign buf_clr = setup_hit && !eng_busy;
    assign buf_we  = bus_we && (state_q == SQ_LOAD) && (first_item || in_window);
    assign buf_idx = first_item ? '0 : offset[IDX_W-1:0];
    assign launch  = bus_we && (state_q == SQ_CONFIRM) && (cmd == CMD_CONFIRM);
    assign launch_start = start_q;
    assign launch_last  = last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            block_q  <= '0;
            start_q  <= '0;
            last_q   <= '0;
            loaded_q <= '0;
            avail    <= 1'b1;
            seq_err  <= 1'b0;
            pgm_err  <= 1'b0;
        end else if (bus_we) begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (cmd == CMD_SETUP) begin
                        if (eng_busy) begin
                            avail <= 1'b0;
                        end else begin
                            avail   <= 1'b1;
                            seq_err <= 1'b0;
                            pgm_err <= 1'b0;
                            block_q <= bus_addr[ADDR_W-1:BLK_LSB];
                            state_q <= SQ_COUNT;
                        end
                    end
                end
                SQ_COUNT: begin
                    if (count_ok) begin
                        last_q   <= bus_wdata[IDX_W-1:0];
                        loaded_q <= '0;
                        state_q  <= SQ_LOAD;
                    end else begin
                        seq_err <= 1'b1;
                        pgm_err <= 1'b1;
                        state_q <= SQ_IDLE;
                    end
                end
                SQ_LOAD: begin
                    if (first_item || in_window) begin
                        if (first_item) begin
                            start_q <= bus_addr;
                        end
                        if (loaded_q == last_q) begin
                            state_q <= SQ_CONFIRM;
                        end else begin
                            loaded_q <= loaded_q + 1'b1;
                        end
                    end else begin
                        seq_err <= 1'b1;
                        pgm_err <= 1'b1;
                        state_q <= SQ_IDLE;
                    end
                end
                SQ_CONFIRM: begin
                    if (cmd != CMD_CONFIRM) begin
                        seq_err <= 1'b1;
                        pgm_err <= 1'b1;
                    end
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wbuf_prog_engine.sv
module wbuf_prog_engine #(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 32,
    parameter int PROG_DELAY = 4,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int TMR_W     = (PROG_DELAY > 2) ? $clog2(PROG_DELAY) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [ADDR_W-1:0] launch_start,
    input  logic [IDX_W-1:0]  launch_last,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              busy,
    output logic              prog_we,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data
);

    localparam logic [TMR_W-1:0] TMR_END = TMR_W'(PROG_DELAY - 1);

    logic [TMR_W-1:0]  tmr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;
    logic [ADDR_W-1:0] base_q;
    logic              step;

    assign step = busy && (tmr_q == TMR_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            tmr_q  <= '0;
            idx_q  <= '0;
            last_q <= '0;
            base_q <= '0;
        end else if (launch) begin
            busy   <= 1'b1;
            tmr_q  <= '0;
            idx_q  <= '0;
            last_q <= launch_last;
            base_q <= launch_start;
        end else if (busy) begin
            if (step) begin
                tmr_q <= '0;
                if (idx_q == last_q) begin
                    busy <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    assign rd_idx    = idx_q;
    assign prog_we   = step;
    assign prog_addr = base_q + ADDR_W'(idx_q);
    assign prog_data = rd_data;

endmodule

// File: rtl/wbuf_program_seq.sv
module wbuf_program_seq
    import wbuf_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 32,
    parameter int BLK_LSB    = 16,
    parameter int PROG_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [7:0]        status_o,
    output logic [7:0]        xstat_o,
    output logic              prog_we,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data
);

    localparam int IDX_W = $clog2(DEPTH);

    logic              buf_clr;
    logic              buf_we;
    logic [IDX_W-1:0]  buf_idx;
    logic              launch;
    logic [ADDR_W-1:0] launch_start;
    logic [IDX_W-1:0]  launch_last;
    logic              avail;
    logic              eng_busy;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;
    stat_flags_t       flags;

    wbuf_cmd_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .BLK_LSB(BLK_LSB)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .eng_busy(eng_busy),
        .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_idx),
        .launch(launch), .launch_start(launch_start), .launch_last(launch_last),
        .avail(avail), .seq_err(flags.seq_err), .pgm_err(flags.pgm_err)
    );

    wbuf_store #(
        .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) u_store (
        .clk(clk), .rst(rst), .clr(buf_clr),
        .we(buf_we), .widx(buf_idx), .wdata(bus_wdata),
        .ridx(rd_idx), .rdata(rd_data)
    );

    wbuf_prog_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .PROG_DELAY(PROG_DELAY)
    ) u_eng (
        .clk(clk), .rst(rst),
        .launch(launch), .launch_start(launch_start), .launch_last(launch_last),
        .rd_data(rd_data), .rd_idx(rd_idx), .busy(eng_busy),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data)
    );

    assign flags.ready = !eng_busy;
    assign status_o    = pack_status(flags);
    assign xstat_o     = pack_xstat(avail);

endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker
    import wbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [7:0]        status_o,
    input logic [7:0]        xstat_o,
    input logic              prog_we
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (status_o == 8'h80 && xstat_o == 8'h80 && !prog_we));

    assert_avail_only_on_setup_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(xstat_o[XS_AVAIL_BIT]) |-> $past(bus_we && bus_wdata[7:0] == CMD_SETUP));

    assert_error_from_write_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[ST_SEQ_BIT]) |-> $past(bus_we));

    assert_error_bits_paired_R5: assert property (@(posedge clk) disable iff (rst)
        status_o[ST_SEQ_BIT] == status_o[ST_PGM_BIT]);

    assert_busy_only_after_confirm_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o[ST_READY_BIT]) |-> $past(bus_we && bus_wdata[7:0] == CMD_CONFIRM));

    assert_strobe_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        prog_we |=> !prog_we);

    assert_not_ready_when_strobing_R9: assert property (@(posedge clk) disable iff (rst)
        prog_we |-> !status_o[ST_READY_BIT]);

endmodule

bind wbuf_program_seq wbuf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .status_o(status_o), .xstat_o(xstat_o), .prog_we(prog_we)
);

// File: tb/tb_wbuf_program_seq.sv
module tb_wbuf_program_seq;

    localparam int AW = 24;
    localparam int DW = 8;
    localparam int D  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [7:0]    status_o, xstat_o;
    logic          prog_we;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;

    wbuf_program_seq #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(32), .BLK_LSB(16), .PROG_DELAY(D)) dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .status_o(status_o), .xstat_o(xstat_o), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_data(prog_data)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    int            log_n = 0;
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    int            log_cyc  [64];

    logic [DW-1:0] exp_mem [32];
    logic [AW-1:0] cur_start;
    int            cur_c;
    bit            first_load;
    int            e0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (prog_we && log_n < 64) begin
            log_addr[log_n] = prog_addr;
            log_data[log_n] = prog_data;
            log_cyc[log_n]  = cyc;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_setup(input logic [AW-1:0] a);
        bus_write(a, 8'h5A);
        for (int i = 0; i < 32; i++) exp_mem[i] = 8'hFF;
        first_load = 1'b1;
    endtask

    task automatic do_count(input logic [AW-1:0] a, input int c);
        bus_write(a, DW'(c));
        cur_c = c;
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_write(a, d);
        if (first_load) begin
            cur_start = a;
            first_load = 1'b0;
        end
        exp_mem[a - cur_start] = d;
    endtask

    task automatic do_confirm;
        log_n = 0;
        bus_write(24'h0, 8'hC3);
        e0 = cyc;
        chk("R9 ready low after confirm", {31'd0, status_o[7]}, 32'd0);
    endtask

    task automatic verify_program(input logic [AW-1:0] start, input int c);
        int target;
        target = e0 + (c + 1) * D - 1;
        while (cyc < target) @(negedge clk);
        chk("R9 ready low before last commit", {31'd0, status_o[7]}, 32'd0);
        @(negedge clk);
        chk("R9 ready back after last commit", {31'd0, status_o[7]}, 32'd1);
        chk("R7 item count", log_n, c + 1);
        for (int k = 0; k <= c && k < log_n; k++) begin
            chk("R7 prog_addr", log_addr[k], start + AW'(k));
            chk("R7 prog_data", log_data[k], exp_mem[k]);
            chk("R8 strobe cycle", log_cyc[k], e0 + k * D + D - 1);
        end
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 status", status_o, 8'h80);
        chk("R1 xstat", xstat_o, 8'h80);
        chk("R1 prog_we", prog_we, 0);
    endtask

    task automatic t_ignored_idle;
        log_n = 0;
        bus_write(24'h010000, 8'h12);
        bus_write(24'h010001, 8'hC3);
        idle_wait(2 * D);
        chk("R10 status unchanged", status_o, 8'h80);
        chk("R10 xstat unchanged", xstat_o, 8'h80);
        chk("R10 no programming", log_n, 0);
    endtask

    task automatic t_basic_aligned;
        do_setup(24'h030000);
        chk("R2 setup avail", xstat_o, 8'h80);
        do_count(24'h030000, 3);
        load(24'h030040, 8'h11);
        load(24'h030041, 8'h22);
        load(24'h030042, 8'h33);
        load(24'h030043, 8'h44);
        chk("R4 no error during load", status_o, 8'h80);
        do_confirm();
        verify_program(24'h030040, 3);
    endtask

    task automatic t_unaligned_full;
        do_setup(24'h030000);
        do_count(24'h03FFFF, 31);
        load(24'h03012B, 8'h80);
        for (int k = 31; k >= 1; k--) load(24'h03012B + AW'(k), DW'(8'h80 + k));
        do_confirm();
        verify_program(24'h03012B, 31);
    endtask

    task automatic t_gaps_overwrite;
        do_setup(24'h050000);
        do_count(24'h050000, 5);
        load(24'h050010, 8'hA1);
        load(24'h050012, 8'hA2);
        load(24'h050012, 8'hA3);
        load(24'h050015, 8'hA4);
        load(24'h050011, 8'hA5);
        load(24'h050012, 8'hA6);
        do_confirm();
        verify_program(24'h050010, 5);
        chk("R7 unloaded offset reads erased", exp_mem[3], 8'hFF);
    endtask

    task automatic t_window_error;
        do_setup(24'h040000);
        do_count(24'h040000, 3);
        load(24'h0400A0, 8'h01);
        log_n = 0;
        bus_write(24'h0400A4, 8'h02);
        chk("R5 above window aborts", status_o, 8'hB0);
        bus_write(24'h0, 8'hC3);
        idle_wait(2 * D);
        chk("R5 no programming after abort", log_n, 0);
        chk("R5 error persists", status_o, 8'hB0);
        do_setup(24'h040000);
        chk("R2 setup clears errors", status_o, 8'h80);
        chk("R2 setup avail", xstat_o, 8'h80);
        do_count(24'h040000, 3);
        load(24'h0400A0, 8'h01);
        bus_write(24'h04009F, 8'h02);
        chk("R5 below window aborts", status_o, 8'hB0);
    endtask

    task automatic t_count_too_big;
        do_setup(24'h020000);
        chk("R2 clear on setup", status_o, 8'h80);
        bus_write(24'h020000, 8'd32);
        chk("R3 count 32 rejected", status_o, 8'hB0);
    endtask

    task automatic t_block_mismatch;
        do_setup(24'h060000);
        bus_write(24'h070000, 8'd2);
        chk("R3 block mismatch rejected", status_o, 8'hB0);
    endtask

    task automatic t_bad_confirm;
        do_setup(24'h080000);
        do_count(24'h080000, 1);
        load(24'h080000, 8'h55);
        load(24'h080001, 8'h66);
        log_n = 0;
        bus_write(24'h0, 8'h00);
        chk("R6 wrong confirm aborts", status_o, 8'hB0);
        idle_wait(3 * D);
        chk("R6 nothing programmed", log_n, 0);
    endtask

    task automatic t_retry_busy;
        do_setup(24'h090000);
        do_count(24'h090000, 7);
        for (int k = 0; k < 8; k++) load(24'h090100 + AW'(k), DW'(8'h30 + k));
        do_confirm();
        bus_write(24'h090000, 8'h5A);
        chk("R2 busy setup reports unavailable", xstat_o, 8'h00);
        chk("R2 busy setup no error", status_o, 8'h00);
        bus_write(24'h090101, 8'hEE);
        chk("R10 write during program ignored", status_o, 8'h00);
        verify_program(24'h090100, 7);
        chk("R2 avail held until retry", xstat_o, 8'h00);
        do_setup(24'h090000);
        chk("R2 retry gets buffer", xstat_o, 8'h80);
        do_count(24'h090000, 0);
        load(24'h0901FF, 8'h7E);
        do_confirm();
        verify_program(24'h0901FF, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ignored_idle();
        t_basic_aligned();
        t_unaligned_full();
        t_gaps_overwrite();
        t_window_error();
        t_count_too_big();
        t_block_mismatch();
        t_bad_confirm();
        t_retry_busy();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule